// File: doc/BRIEF.md
# Three-Channel Selectable-Source Clock Output Divider

This block drives three clock output pins. Each pin has its own 8-bit control register, and the registers sit at consecutive addresses that start at a base address. A channel picks one of two sources: a low-speed 32768 Hz reference or a fast source of roughly 4 MHz. The fast source first passes through a table-driven pre-divider. The result then goes through a power-of-two post-divider, and an enable bit gates the output. The low-speed source skips the pre-divider and feeds the post-divider directly.

The block runs on one system clock. Each source appears as a single-cycle tick pulse, one pulse for every edge of that source, so two ticks make one source cycle. A channel with a total division N changes its output level once every N ticks of the selected source. This gives an output period of N source cycles with equal high and low phases. Register writes land at once in a shadow register. The divider only takes up the new setting at the end of an output period, or at once while the channel is idle, so the output never produces a shortened pulse.

Top module: `clkout_bank`

## Requirements
- R1: After reset every output is low and every channel is disabled. Outputs stay low until a register is written.
- R2: A write with `wr_addr` equal to base address + i (i = 0, 1, 2; base 4 by default) loads channel i's control register and no other. A write to any other address changes no output.
- R3: Control bit 0 is the enable. While a channel is disabled its output is held low, whatever the source ticks do.
- R4: Control bit 4 selects the source: 0 counts `slow_tick` pulses and 1 counts `fast_tick` pulses.
- R5: Control bits 3:1 hold an exponent E. The post-divider passes one of every 2^E incoming ticks.
- R6: Control bits 7:5 select the fast-source pre-divider ratio. Codes 0 to 6 give 1, 2, 4, 8, 16, 32 and 64, and code 7 gives 122. The field has no effect when bit 4 is 0.
- R7: While a channel runs, its high and low phases each last exactly N selected-source ticks, where N = pre-divider ratio times 2^E. With ratio 122 the output changes level every 61 source cycles.
- R8: Clearing the enable while the output is high lets the current high phase finish at full length. The output then stays low.
- R9: A new setting written while a channel runs takes effect only when the output next falls. Both divider counters then restart from zero, so the phase that follows already uses the new ratio.
- R10: A write that lands in the same cycle as a falling output is applied at that same boundary.
- R11: Enabling an idle channel starts counting from zero with the ticks after the write cycle. The first rise comes after N ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_tick | input | 1 | One pulse per edge of the 32768 Hz source |
| fast_tick | input | 1 | One pulse per edge of the fast source |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (4) | Register write address |
| wr_data | input | 8 | Control register write data |
| clk_out | output | NUM_CH (3) | Divided clock outputs, one per channel |

## Verification
Two events can fall in the same cycle: a host register write and the falling output edge that closes a period. When they meet, the write must be forwarded into the active setting rather than wait a full extra period. The bench provokes this by counting fast ticks during a high phase. It issues the write exactly when the tick that completes the phase is being driven. It then judges the result by the length of the next low phase, which must already match the new ratio. Alongside this, disable and reconfiguration writes in the middle of a phase are checked by measuring every phase length in source ticks.

// File: rtl/clkout_pkg.sv
package clkout_pkg;

  // Control register layout; the field positions are decoded by the channel.
  typedef struct packed {
    logic [2:0] pre_sel;   // 7:5 fast-source pre-divider code
    logic       src_fast;  // 4   1 = fast source, 0 = 32768 Hz source
    logic [2:0] post_exp;  // 3:1 post-divider exponent
    logic       en;        // 0   output enable
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);

  // Pre-divider ratio: powers of two except the top code.
  function automatic int unsigned pre_ratio(input logic [2:0] code,
                                            input int unsigned top_ratio);
    if (code == 3'd7) return top_ratio;
    return 32'd1 << code;
  endfunction

  // Post-divider ratio: 2 raised to the exponent.
  function automatic int unsigned post_ratio(input logic [2:0] expo);
    return 32'd1 << expo;
  endfunction

endpackage

// File: rtl/clkout_prediv.sv
module clkout_prediv
  import clkout_pkg::*;
#(
  parameter int unsigned TOP_RATIO = 122,
  localparam int unsigned MAX_RATIO = (TOP_RATIO > 64) ? TOP_RATIO : 64,
  localparam int unsigned CNT_W = $clog2(MAX_RATIO)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       src_tick,
  input  logic [2:0] code,
  output logic       pre_tick
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;
  logic             at_limit;

  always_comb limit = CNT_W'(pre_ratio(code, TOP_RATIO) - 1);
  assign at_limit = (cnt_q == limit);
  assign pre_tick = src_tick && at_limit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (clr)      cnt_q <= '0;
    else if (src_tick) cnt_q <= at_limit ? '0 : cnt_q + 1'b1;
  end

  // R6: the count never passes the ratio chosen by the active code
  a_r6_pre_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= limit);

  // R9: a clear always leaves the counter at zero
  a_r9_pre_restart: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));

endmodule

// File: rtl/clkout_postdiv.sv
module clkout_postdiv
  import clkout_pkg::*;
#(
  parameter int unsigned EXP_W = 3,
  localparam int unsigned CNT_W = (1 << EXP_W) - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             in_tick,
  input  logic [EXP_W-1:0] expo,
  output logic             out_tick
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;
  logic             at_limit;

  always_comb limit = CNT_W'(post_ratio(3'(expo)) - 1);
  assign at_limit = (cnt_q == limit);
  assign out_tick = in_tick && at_limit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (clr)     cnt_q <= '0;
    else if (in_tick) cnt_q <= at_limit ? '0 : cnt_q + 1'b1;
  end

  // R5: the count stays below 2^E
  a_r5_post_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= limit);

endmodule

// File: rtl/clkout_channel.sv
module clkout_channel
  import clkout_pkg::*;
#(
  parameter int unsigned TOP_RATIO = 122
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              slow_tick,
  input  logic              fast_tick,
  output logic              clk_out
);

  ctrl_t shadow_q;   // last value written by the host
  ctrl_t active_q;   // setting the dividers run from
  ctrl_t next_cfg;
  logic  out_q;

  logic running, fast_src_tick, fast_pre_tick, stage_tick;
  logic flip, period_end, load;

  // A write in the load cycle is forwarded straight into the active setting.
  assign next_cfg = wr_hit ? ctrl_t'(wr_data) : shadow_q;

  assign running       = active_q.en;
  assign fast_src_tick = running && active_q.src_fast && fast_tick;

  clkout_prediv #(.TOP_RATIO(TOP_RATIO)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (load),
    .src_tick (fast_src_tick),
    .code     (active_q.pre_sel),
    .pre_tick (fast_pre_tick)
  );

  // The slow source bypasses the pre-divider.
  assign stage_tick = running && (active_q.src_fast ? fast_pre_tick : slow_tick);

  clkout_postdiv #(.EXP_W(3)) u_post (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (load),
    .in_tick  (stage_tick),
    .expo     (active_q.post_exp),
    .out_tick (flip)
  );

  assign period_end = flip && out_q;
  assign load       = !running || period_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      active_q <= '0;
      out_q    <= 1'b0;
    end else begin
      if (wr_hit) shadow_q <= ctrl_t'(wr_data);
      if (load)   active_q <= next_cfg;
      if (flip)   out_q    <= ~out_q;
    end
  end

  assign clk_out = out_q;

  // R3: a disabled channel never drives high
  a_r3_low_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !active_q.en |-> !out_q);

  // R8: the enable drops only together with a low output
  a_r8_stop_on_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active_q.en) |-> !out_q);

  // R9: the active setting changes only while the output is low
  a_r9_swap_when_low: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q != $past(active_q)) |-> !out_q);

  // R7: each output change is caused by a divided tick
  a_r7_flip_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (out_q != $past(out_q)) |-> $past(stage_tick));

endmodule

// File: rtl/clkout_bank.sv
module clkout_bank
  import clkout_pkg::*;
#(
  parameter int unsigned NUM_CH    = 3,
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned BASE_ADDR = 4,
  parameter int unsigned TOP_RATIO = 122
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_tick,
  input  logic              fast_tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic [NUM_CH-1:0] clk_out
);

  localparam logic [ADDR_W:0] LO_ADDR = (ADDR_W+1)'(BASE_ADDR);
  localparam logic [ADDR_W:0] HI_ADDR = (ADDR_W+1)'(BASE_ADDR + NUM_CH - 1);

  logic [NUM_CH-1:0] hit;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign hit[i] = wr_en && (wr_addr == ADDR_W'(BASE_ADDR + i));

    clkout_channel #(.TOP_RATIO(TOP_RATIO)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_hit    (hit[i]),
      .wr_data   (wr_data),
      .slow_tick (slow_tick),
      .fast_tick (fast_tick),
      .clk_out   (clk_out[i])
    );
  end

  // R2: at most one channel takes a write
  a_r2_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit));

  // R2: addresses outside the window select nothing
  a_r2_outside_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (({1'b0, wr_addr} < LO_ADDR) || ({1'b0, wr_addr} > HI_ADDR)))
      |-> (hit == '0));

endmodule

// File: tb/clkout_bank_test.sv
module clkout_bank_test;

  localparam int NCH  = 3;
  localparam int BASE = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       slow_tick = 1'b0;
  logic       fast_tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] clk_out;

  always #4 clk = ~clk;

  clkout_bank uut (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .fast_tick(fast_tick),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .clk_out(clk_out)
  );

  // {channel[3:0], control[7:0], expected ticks per phase[11:0]}
  localparam logic [23:0] VEC [10] = '{
    24'h0E1001, 24'h207008, 24'h111001, 24'h055010, 24'h1F107A,
    24'h2D3080, 24'h0F30F4, 24'h1AF080, 24'h23F100, 24'h0BB400
  };

  int   checks = 0, fails = 0;
  int   cyc = 0, tick_ct = 0, nint = 0, watch = 0;
  bit   watch_fast = 0, zero_next = 0;
  int   intv [16];
  logic lvl [16];
  logic [2:0] last_out = '0;
  int   chg [3];
  bit   ch_on [3];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic observe();
    if (watch_fast ? fast_tick : slow_tick) tick_ct++;
    if (zero_next) begin tick_ct = 0; zero_next = 0; end
    for (int c = 0; c < NCH; c++) begin
      if (clk_out[c] !== last_out[c]) begin
        chg[c]++;
        last_out[c] = clk_out[c];
        if (c == watch && nint < 16) begin
          intv[nint] = tick_ct;
          lvl[nint]  = clk_out[c];
          nint++;
          tick_ct = 0;
        end
      end
    end
  endtask

  task automatic drive();
    cyc++;
    slow_tick = (cyc % 5 == 0);
    fast_tick = (cyc % 2 == 0);
  endtask

  task automatic step();
    @(negedge clk);
    observe();
    wr_en = 1'b0;
    drive();
  endtask

  task automatic put(input int addr, input logic [7:0] data, input bit zero);
    @(negedge clk);
    observe();
    wr_en = 1'b1;
    wr_addr = 4'(addr);
    wr_data = data;
    if (zero) zero_next = 1;
    drive();
  endtask

  task automatic wait_n(input int k);
    while (nint < k) step();
  endtask

  task automatic arm(input int ch, input logic [7:0] ctrl);
    watch = ch;
    watch_fast = ctrl[4];
    nint = 0;
    put(BASE + ch, ctrl, 1);
    ch_on[ch] = 1;
  endtask

  task automatic quiesce(input int ch);
    int need;
    if (ch_on[ch]) begin
      watch = ch;
      need = last_out[ch] ? 1 : 2;
      put(BASE + ch, 8'h00, 0);
      nint = 0;
      wait_n(need);
      ch_on[ch] = 0;
    end
    repeat (3) step();
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int base_chg [3];
    bit done;
    for (int c = 0; c < NCH; c++) begin chg[c] = 0; ch_on[c] = 0; end

    // R1: reset state
    repeat (5) step();
    chk(clk_out == 3'b000, "R1", "outputs in reset", int'(clk_out), 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (60) step();
    chk(chg[0] + chg[1] + chg[2] == 0, "R1", "idle after reset changes",
        chg[0] + chg[1] + chg[2], 0);

    // R2: unmapped addresses; R3: enable clear with fast source chosen
    put(BASE + 3, 8'h11, 0);
    put(BASE - 1, 8'h11, 0);
    put(15, 8'h11, 0);
    put(BASE, 8'h10, 0);
    repeat (100) step();
    chk(chg[0] + chg[1] + chg[2] == 0, "R2", "changes after unmapped writes",
        chg[0] + chg[1] + chg[2], 0);
    chk(clk_out[0] == 1'b0, "R3", "disabled channel level", int'(clk_out[0]), 0);

    // R4 R5 R6 R7 R11: vector table
    for (int v = 0; v < 10; v++) begin
      int ch, n;
      logic [7:0] ctrl;
      ch = int'(VEC[v][23:20]);
      ctrl = VEC[v][19:12];
      n = int'(VEC[v][11:0]);
      for (int c = 0; c < NCH; c++) base_chg[c] = chg[c];
      arm(ch, ctrl);
      wait_n(3);
      chk(intv[0] == n && lvl[0] == 1'b1, "R11/R4/R6", "first high after ticks",
          intv[0], n);
      chk(intv[1] == n, "R5/R6", "high phase ticks", intv[1], n);
      chk(intv[2] == intv[1], "R7", "low phase equals high", intv[2], intv[1]);
      for (int c = 0; c < NCH; c++)
        if (c != ch)
          chk(chg[c] == base_chg[c], "R2", "other channel changes",
              chg[c] - base_chg[c], 0);
      quiesce(ch);
    end

    // R8: disable during high phase finishes the phase, then stays low
    arm(0, 8'h07);
    wait_n(1);
    put(BASE, 8'h00, 0);
    ch_on[0] = 0;
    wait_n(2);
    chk(intv[1] == 8 && lvl[1] == 1'b0, "R8", "high phase after disable", intv[1], 8);
    repeat (300) step();
    chk(nint == 2, "R8", "changes after disable", nint, 2);

    // R9: change written during high phase
    arm(0, 8'h55);
    wait_n(1);
    put(BASE, 8'h51, 0);
    wait_n(4);
    chk(intv[1] == 16, "R9", "old high phase kept", intv[1], 16);
    chk(intv[2] == 4, "R9", "low phase uses new ratio", intv[2], 4);
    chk(intv[3] == 4, "R9", "next high new ratio", intv[3], 4);
    quiesce(0);

    // R9: change written during low phase
    arm(1, 8'h55);
    wait_n(2);
    put(BASE + 1, 8'h51, 0);
    wait_n(5);
    chk(intv[2] == 16, "R9", "old high after low write", intv[2], 16);
    chk(intv[3] == 16, "R9", "old low finished", intv[3], 16);
    chk(intv[4] == 4, "R9", "new ratio after fall", intv[4], 4);
    quiesce(1);

    // R10: write in the same cycle as the falling edge
    arm(2, 8'h55);
    wait_n(1);
    done = 0;
    while (!done) begin
      @(negedge clk);
      observe();
      wr_en = 1'b0;
      if (clk_out[2] && tick_ct == 15 && ((cyc + 1) % 2 == 0)) begin
        wr_en = 1'b1;
        wr_addr = 4'(BASE + 2);
        wr_data = 8'h51;
        done = 1;
      end
      drive();
    end
    wait_n(4);
    chk(intv[1] == 16 && lvl[1] == 1'b0, "R10", "fall at boundary", intv[1], 16);
    chk(intv[2] == 4, "R10", "low phase after same-cycle write", intv[2], 4);
    chk(intv[3] == 4, "R10", "high phase after same-cycle write", intv[3], 4);
    quiesce(2);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule